// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Controller

This block holds the status byte of a 64K x 8 serial flash and decides which program and erase requests may reach the array. It receives strobes that an opcode decoder has already produced: write enable, write disable, write status with a data byte, byte program, sector erase, block erase, chip erase and auto-increment program. It also takes a target address, the active-low hardware protect pin and a one-cycle completion pulse from the array sequencer.

Each request is either accepted or rejected. An accepted program or erase starts the sequencer with a one-cycle start pulse and an operation code, then holds the part busy until the completion pulse arrives. Permission depends on three things: a write-enable latch that clears itself after an operation, a protected upper range of the array chosen by two level bits, and a lock bit that freezes those level bits only while the protect pin is held low. Chip erase and block erase follow their own protection rules.

Top module: `sflash_wprot_ctl`

## Requirements
- R1: The status byte is {lock, auto_mode, 0, 0, level[1], level[0], wen, busy}, with busy in bit 0, wen in bit 1, the level bits in bits 3:2, auto_mode in bit 6 and lock in bit 7. Bits 5:4 always read 0. After reset the byte reads 0x0C (level 11, all else 0).
- R2: An accepted byte program, sector erase, block erase, chip erase or auto-increment request sets busy and pulses start_o for one cycle, both on the next clock edge. op_kind_o then holds 1 for byte program, 2 for sector erase, 3 for block erase, 4 for chip erase and 5 for auto-increment. busy clears on the edge that samples op_done_i. op_done_i has no effect while busy is 0.
- R3: While busy is 1, every request strobe (including write enable and write disable) is ignored. It raises neither accept_o nor reject_o and changes no status bit.
- R4: Write enable sets wen and write disable clears wen. Both pulse accept_o. Any program, erase or write-status request made while wen is 0 is rejected.
- R5: wen clears on the completion of a byte program, sector erase, block erase or chip erase.
- R6: An accepted write-status request loads level[0] from data bit 2, level[1] from data bit 3 and lock from data bit 7, and clears wen. While wp_n_i is 0 and lock is 1, write-status is rejected. While wp_n_i is 1, lock has no effect.
- R7: Byte program, sector erase and auto-increment reject a target inside the protected range. Level 00 protects nothing, 01 protects 0xC000-0xFFFF, 10 protects 0x8000-0xFFFF and 11 protects the whole array.
- R8: Block erase ignores level 01. Levels 10 and 11 apply to it as in R7.
- R9: Chip erase is accepted only when both level bits are 0.
- R10: An accepted auto-increment request sets auto_mode and programs addr_i. While auto_mode is 1, a further auto-increment request programs the previous address plus one, and every other program, erase or write-status request is rejected. Completion at address 0xFFFF clears wen and auto_mode. Any other auto-increment completion keeps wen. Write disable clears auto_mode.
- R11: Each decided request pulses exactly one of accept_o or reject_o for one cycle, on the next clock edge. A rejected request changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| wren_i | input | 1 | Write-enable strobe |
| wrdi_i | input | 1 | Write-disable strobe |
| wrsr_i | input | 1 | Write-status strobe |
| sr_data_i | input | 8 | Data byte for write-status |
| prog_i | input | 1 | Byte-program strobe |
| sec_erase_i | input | 1 | Sector-erase strobe |
| blk_erase_i | input | 1 | Block-erase strobe |
| chip_erase_i | input | 1 | Chip-erase strobe |
| aai_start_i | input | 1 | Auto-increment program strobe |
| addr_i | input | ADDR_W | Target address |
| wp_n_i | input | 1 | Hardware write-protect pin, active low |
| op_done_i | input | 1 | Completion pulse from array sequencer |
| status_o | output | 8 | Status byte |
| accept_o | output | 1 | Request accepted pulse |
| reject_o | output | 1 | Request rejected pulse |
| start_o | output | 1 | Start pulse to sequencer |
| op_kind_o | output | 3 | Operation code of the last start |

## Verification
The bench builds the block with ADDR_W at its default of 16, so the full 64K address map is covered. With that width, the quarter and half protection boundaries sit at 0xC000 and 0x8000, and the bench probes both sides of each. It can also start auto-increment programming at 0xFFFE and reach the top-address completion in two steps, which brings the rule that clears the latch at the top address within a short run.

// File: rtl/sflash_wprot_ctl.sv
module sflash_wprot_ctl #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [7:0]        sr_data_i,
  input  logic              prog_i,
  input  logic              sec_erase_i,
  input  logic              blk_erase_i,
  input  logic              chip_erase_i,
  input  logic              aai_start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wp_n_i,
  input  logic              op_done_i,
  output logic [7:0]        status_o,
  output logic              accept_o,
  output logic              reject_o,
  output logic              start_o,
  output logic [2:0]        op_kind_o
);

  localparam logic [ADDR_W-1:0] ADDR_TOP = '1;
  localparam logic [2:0] K_WSR  = 3'd0;
  localparam logic [2:0] K_PROG = 3'd1;
  localparam logic [2:0] K_SEC  = 3'd2;
  localparam logic [2:0] K_BLK  = 3'd3;
  localparam logic [2:0] K_CHIP = 3'd4;
  localparam logic [2:0] K_AAI  = 3'd5;

  logic              busy, wen, lock, auto_mode;
  logic [1:0]        level;
  logic [ADDR_W-1:0] auto_addr;

  logic              is_req, req_ok;
  logic [2:0]        req_kind;
  logic [ADDR_W-1:0] req_addr;

  function automatic logic guarded(input logic [1:0] lvl, input logic [ADDR_W-1:0] a);
    case (lvl)
      2'b00:   guarded = 1'b0;
      2'b01:   guarded = &a[ADDR_W-1 -: 2];
      2'b10:   guarded = a[ADDR_W-1];
      default: guarded = 1'b1;
    endcase
  endfunction

  wire              locked    = !wp_n_i && lock;
  wire [1:0]        blk_level = (level == 2'b01) ? 2'b00 : level;
  wire [ADDR_W-1:0] auto_next = auto_addr + 1'b1;

  always_comb begin
    is_req   = 1'b1;
    req_ok   = 1'b0;
    req_kind = K_WSR;
    req_addr = addr_i;
    if (wrsr_i) begin
      req_ok = wen && !locked && !auto_mode;
    end else if (chip_erase_i) begin
      req_kind = K_CHIP;
      req_ok   = wen && !auto_mode && (level == 2'b00);
    end else if (blk_erase_i) begin
      req_kind = K_BLK;
      req_ok   = wen && !auto_mode && !guarded(blk_level, addr_i);
    end else if (sec_erase_i) begin
      req_kind = K_SEC;
      req_ok   = wen && !auto_mode && !guarded(level, addr_i);
    end else if (prog_i) begin
      req_kind = K_PROG;
      req_ok   = wen && !auto_mode && !guarded(level, addr_i);
    end else if (aai_start_i) begin
      req_kind = K_AAI;
      req_addr = auto_mode ? auto_next : addr_i;
      req_ok   = wen && !guarded(level, req_addr);
    end else begin
      is_req = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      wen       <= 1'b0;
      lock      <= 1'b0;
      auto_mode <= 1'b0;
      level     <= 2'b11;
      auto_addr <= '0;
      accept_o  <= 1'b0;
      reject_o  <= 1'b0;
      start_o   <= 1'b0;
      op_kind_o <= K_WSR;
    end else begin
      accept_o <= 1'b0;
      reject_o <= 1'b0;
      start_o  <= 1'b0;
      if (busy) begin
        if (op_done_i) begin
          busy <= 1'b0;
          if (!auto_mode || auto_addr == ADDR_TOP) begin
            wen       <= 1'b0;
            auto_mode <= 1'b0;
          end
        end
      end else if (wrdi_i) begin
        wen       <= 1'b0;
        auto_mode <= 1'b0;
        accept_o  <= 1'b1;
      end else if (wren_i) begin
        wen      <= 1'b1;
        accept_o <= 1'b1;
      end else if (is_req) begin
        if (!req_ok) begin
          reject_o <= 1'b1;
        end else begin
          accept_o <= 1'b1;
          if (req_kind == K_WSR) begin
            level <= sr_data_i[3:2];
            lock  <= sr_data_i[7];
            wen   <= 1'b0;
          end else begin
            busy      <= 1'b1;
            start_o   <= 1'b1;
            op_kind_o <= req_kind;
            if (req_kind == K_AAI) begin
              auto_mode <= 1'b1;
              auto_addr <= req_addr;
            end
          end
        end
      end
    end
  end

  assign status_o = {lock, auto_mode, 2'b00, level, wen, busy};

endmodule

// File: rtl/sflash_wprot_chk.sv
module sflash_wprot_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wren_i,
  input logic       wrdi_i,
  input logic       wrsr_i,
  input logic       prog_i,
  input logic       sec_erase_i,
  input logic       blk_erase_i,
  input logic       chip_erase_i,
  input logic       aai_start_i,
  input logic       op_done_i,
  input logic [7:0] status_o,
  input logic       accept_o,
  input logic       reject_o,
  input logic       start_o,
  input logic [2:0] op_kind_o
);

  wire any_gated = wrsr_i | prog_i | sec_erase_i | blk_erase_i | chip_erase_i | aai_start_i;

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[5:4] == 2'b00);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> status_o[0]);

  assert_busy_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[0] && !op_done_i |=> status_o[0] && $stable(status_o[7:1]));

  assert_busy_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[0] |=> !accept_o && !reject_o);

  assert_no_wen_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    any_gated && !wren_i && !wrdi_i && !status_o[0] && !status_o[1] |=> reject_o && !start_o);

  assert_chip_unprotected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_o && op_kind_o == 3'd4 |-> status_o[3:2] == 2'b00);

  assert_one_verdict_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept_o && reject_o));

  assert_reject_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reject_o |-> $stable(status_o));

endmodule

bind sflash_wprot_ctl sflash_wprot_chk chk_i (.*);

// File: tb/sflash_wprot_ctl_tb_top.sv
module sflash_wprot_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wren_i = 0, wrdi_i = 0, wrsr_i = 0, prog_i = 0, sec_erase_i = 0;
  logic blk_erase_i = 0, chip_erase_i = 0, aai_start_i = 0, op_done_i = 0;
  logic wp_n_i = 1'b1;
  logic [7:0] sr_data_i = '0;
  logic [15:0] addr_i = '0;
  logic [7:0] status_o;
  logic accept_o, reject_o, start_o;
  logic [2:0] op_kind_o;

  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  sflash_wprot_ctl #(.ADDR_W(16)) dut_i (.*);

  // reference model state
  bit m_busy, m_wen, m_lock, m_auto, m_acc, m_rej, m_start;
  int m_level, m_aaddr, m_kind;

  function automatic bit in_guard(int lvl, int a);
    int lo;
    lo = (lvl == 1) ? 'hC000 : (lvl == 2) ? 'h8000 : (lvl == 3) ? 0 : 'h10000;
    return a >= lo;
  endfunction

  task automatic check(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int tgt;
    bit ok;
    if (!rst_n) begin
      m_busy = 0; m_wen = 0; m_lock = 0; m_auto = 0; m_level = 3; m_aaddr = 0;
      m_acc = 0; m_rej = 0; m_start = 0; m_kind = 0;
    end else begin
      m_acc = 0; m_rej = 0; m_start = 0;
      if (m_busy) begin
        if (op_done_i) begin
          m_busy = 0;
          if (!m_auto || m_aaddr == 'hFFFF) begin m_wen = 0; m_auto = 0; end
        end
      end else if (wrdi_i) begin m_wen = 0; m_auto = 0; m_acc = 1; end
      else if (wren_i) begin m_wen = 1; m_acc = 1; end
      else if (wrsr_i) begin
        if (m_wen && !m_auto && !(!wp_n_i && m_lock)) begin
          m_level = sr_data_i[3:2]; m_lock = sr_data_i[7]; m_wen = 0; m_acc = 1;
        end else m_rej = 1;
      end else if (chip_erase_i | blk_erase_i | sec_erase_i | prog_i | aai_start_i) begin
        tgt = addr_i;
        if (chip_erase_i) begin m_kind = 4; ok = m_level == 0; end
        else if (blk_erase_i) begin m_kind = 3; ok = !in_guard(m_level == 1 ? 0 : m_level, tgt); end
        else if (sec_erase_i) begin m_kind = 2; ok = !in_guard(m_level, tgt); end
        else if (prog_i) begin m_kind = 1; ok = !in_guard(m_level, tgt); end
        else begin
          if (m_auto) tgt = m_aaddr + 1;
          ok = !in_guard(m_level, tgt);
        end
        if (!aai_start_i || chip_erase_i || blk_erase_i || sec_erase_i || prog_i) ok = ok && !m_auto;
        else m_kind = 5;
        ok = ok && m_wen;
        if (ok) begin
          m_acc = 1; m_start = 1; m_busy = 1;
          if (m_kind == 5) begin m_auto = 1; m_aaddr = tgt; end
        end else m_rej = 1;
      end
    end
    #5;
    check("R1 status", status_o, {m_lock, m_auto, 2'b00, m_level[1:0], m_wen, m_busy});
    check("R11 accept", accept_o, m_acc);
    check("R11 reject", reject_o, m_rej);
    check("R2 start", start_o, m_start);
    if (m_start) check("R2 kind", op_kind_o, m_kind);
  end

  task automatic pulse(ref logic s, input int a = 0, input int d = 0);
    @(negedge clk);
    addr_i = a[15:0]; sr_data_i = d[7:0]; s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", status_o, 8'h0C);
    pulse(prog_i, 'h0000);
    check("R4 no wen", reject_o, 1);
    pulse(wren_i);
    check("R4 wen set", status_o, 8'h0E);
    pulse(wrsr_i, 0, 'h00);
    check("R6 wrsr", status_o, 8'h00);
    pulse(wren_i);
    pulse(prog_i, 'h1234);
    check("R2 busy", status_o, 8'h03);
    check("R2 kind", op_kind_o, 1);
    pulse(wrdi_i);
    check("R3 ignored", {accept_o, reject_o, status_o}, 10'h003);
    pulse(op_done_i);
    check("R5 done", status_o, 8'h00);
    pulse(op_done_i);
    check("R2 idle done", status_o, 8'h00);
    pulse(wren_i); pulse(wrsr_i, 0, 'h04);
    pulse(wren_i); pulse(prog_i, 'hC000);
    check("R7 quarter", {reject_o, status_o}, 9'h106);
    pulse(prog_i, 'hBFFF);
    check("R7 below", start_o, 1);
    pulse(op_done_i);
    pulse(wren_i); pulse(blk_erase_i, 'hF000);
    check("R8 level1", start_o, 1);
    pulse(op_done_i);
    pulse(wren_i); pulse(chip_erase_i);
    check("R9 chip level1", reject_o, 1);
    pulse(wrsr_i, 0, 'h88);
    check("R6 lock set", status_o, 8'h88);
    pulse(wren_i); pulse(blk_erase_i, 'h9000);
    check("R8 level2", reject_o, 1);
    pulse(sec_erase_i, 'h7FFF);
    check("R7 half below", start_o, 1);
    pulse(op_done_i);
    wp_n_i = 1'b0;
    pulse(wren_i); pulse(wrsr_i, 0, 'h00);
    check("R6 locked", {reject_o, status_o}, 9'h18A);
    wp_n_i = 1'b1;
    pulse(wrsr_i, 0, 'h00);
    check("R6 pin high", status_o, 8'h00);
    pulse(wren_i); pulse(chip_erase_i);
    check("R9 chip ok", op_kind_o, 4);
    pulse(op_done_i);
    pulse(aai_start_i, 'h10);
    check("R10 no wen", reject_o, 1);
    pulse(wren_i); pulse(aai_start_i, 'hFFFE);
    check("R10 auto", status_o, 8'h43);
    pulse(op_done_i);
    check("R10 keep wen", status_o, 8'h42);
    pulse(prog_i, 'h10);
    check("R10 other rejected", reject_o, 1);
    pulse(aai_start_i, 'h0);
    pulse(op_done_i);
    check("R10 top", status_o, 8'h00);
    pulse(wren_i); pulse(aai_start_i, 'h20);
    pulse(op_done_i);
    pulse(wrdi_i);
    check("R10 exit", status_o, 8'h00);
    pulse(wren_i); pulse(wrsr_i, 0, 'h0C);
    pulse(wren_i); pulse(aai_start_i, 'h0);
    check("R7 full", reject_o, 1);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule